// File: doc/BRIEF.md
# Hypercube Matrix Transpose Network

This block holds an n×n matrix, with n = 2^Q, spread one element per processing element (PE) over n² PEs that are wired as a hypercube. PE number k holds the matrix entry at row k / n, column k mod n. The upper Q bits of the PE index are the row and the lower Q bits are the column. Each PE has a working register and a spare buffer register. The whole array is written in one cycle through a wide load port, and the working registers can always be read through a wide read port.

A start pulse runs the transpose. The network makes Q rounds, one for each address bit m from 2Q-1 down to Q. Each round pairs bit m with bit m-Q and takes two one-cycle moves. In the first move, each PE whose bits m and m-Q differ copies its working value into the buffer of its neighbour across bit m. In the second move, each PE whose two bits match copies its buffer into the working register of its neighbour across bit m-Q. One round swaps the upper-right and lower-left sub-blocks at one level of a recursive quadrant split. The other two sub-blocks are left in place. After the last move the element first held by PE i·n+j sits in PE j·n+i, and `done` pulses for one cycle.

Top module: `hcube_transpose`

## Requirements
- R1: While the block is idle, a cycle with `load` high writes lane k of `load_data` (bits k·W+W-1 down to k·W) into PE k. From the next cycle, lane k of `rd_data` shows PE k's working register.
- R2: After a run completes, lane j·n+i of `rd_data` equals lane i·n+j as it was at start, for every i and j.
- R3: After the first round (two cycles into the run), only the upper-right and lower-left quadrants have been swapped. For the default size, a row-major matrix abcd/efgh/ijkl/mnop reads abij/efmn/cdkl/ghop.
- R4: A start accepted at a clock edge makes `busy` high for exactly 2Q cycles. `done` is high for exactly one cycle, in the first cycle where `busy` is low again.
- R5: `start` is ignored while `busy` is high. The run neither restarts nor stretches.
- R6: `load` is ignored while `busy` is high. The run result is unaffected.
- R7: Lanes on the diagonal (index i·n+i) never change during a run.
- R8: Reset clears `busy` and `done`, and sets every working register to zero.
- R9: When `load` and `start` are both high in an idle cycle, the load takes effect and the start is dropped.
- R10: While idle without `load`, `rd_data` holds its value, including in the cycle where `start` is taken.
- R11: Two back-to-back runs return the original matrix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Parallel write of all PEs when idle |
| load_data | input | W·2^(2Q) | One W-bit lane per PE, lane k for PE k |
| start | input | 1 | Begin a transpose when idle |
| busy | output | 1 | Transpose in progress |
| done | output | 1 | One-cycle pulse when the transpose ends |
| rd_data | output | W·2^(2Q) | Working register of every PE, lane k for PE k |

## Verification
The checker assumes `rst_n` is held low before the first edge. It also assumes the only way to alter the matrix is through `load` while idle. The diagonal-hold and idle-hold properties depend on that assumption. The stimulus drives and samples on the falling edge and releases reset before any request. During runs it deliberately raises `start` and `load` together. These extra requests are accepted by the assumptions, since they must be ignored. The run-length property counts busy cycles in the checker, so it needs no bound on how far apart runs are.

// File: rtl/hcube_transpose.sv
module hcube_transpose #(
  parameter int Q = 2,
  parameter int W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [(W<<(2*Q))-1:0]      load_data,
  input  logic                       start,
  output logic                       busy,
  output logic                       done,
  output logic [(W<<(2*Q))-1:0]      rd_data
);
  localparam int IW = 2 * Q;
  localparam int N  = 1 << IW;
  localparam int MW = $clog2(IW) + 1;

  typedef logic [IW-1:0] idx_t;

  logic [W-1:0]  a_q [N];
  logic [W-1:0]  b_q [N];
  logic [W-1:0]  a_d [N];
  logic [W-1:0]  b_d [N];
  logic          busy_q, done_q, ph_q;
  logic [MW-1:0] m_q, lo;

  wire ld = load && !busy_q;
  wire go = start && !load && !busy_q;

  assign lo   = m_q - MW'(Q);
  assign busy = busy_q;
  assign done = done_q;

  function automatic logic bit_at(input int v, input logic [MW-1:0] p);
    idx_t x;
    x = idx_t'(v);
    return x[p];
  endfunction

  function automatic idx_t flip(input int v, input logic [MW-1:0] p);
    return idx_t'(v) ^ (idx_t'(1) << p);
  endfunction

  always_comb begin
    for (int v = 0; v < N; v++) begin
      a_d[v] = a_q[v];
      b_d[v] = b_q[v];
      if (ld) begin
        a_d[v] = load_data[v*W +: W];
      end else if (busy_q) begin
        if (!ph_q) begin
          if (bit_at(v, m_q) == bit_at(v, lo)) b_d[v] = a_q[flip(v, m_q)];
        end else begin
          if (bit_at(v, m_q) != bit_at(v, lo)) a_d[v] = b_q[flip(v, lo)];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < N; v++) begin
        a_q[v] <= '0;
        b_q[v] <= '0;
      end
    end else begin
      for (int v = 0; v < N; v++) begin
        a_q[v] <= a_d[v];
        b_q[v] <= b_d[v];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ph_q   <= 1'b0;
      m_q    <= MW'(IW - 1);
    end else begin
      done_q <= 1'b0;
      if (go) begin
        busy_q <= 1'b1;
        ph_q   <= 1'b0;
        m_q    <= MW'(IW - 1);
      end else if (busy_q) begin
        if (!ph_q) begin
          ph_q <= 1'b1;
        end else begin
          ph_q <= 1'b0;
          if (m_q == MW'(Q)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            m_q <= m_q - MW'(1);
          end
        end
      end
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_rd
    assign rd_data[k*W +: W] = a_q[k];
  end
endmodule

// File: rtl/hcube_transpose_chk.sv
module hcube_transpose_chk #(
  parameter int Q = 2,
  parameter int W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  load,
  input logic                  start,
  input logic                  busy,
  input logic                  done,
  input logic [(W<<(2*Q))-1:0] rd_data
);
  localparam int NS = 1 << Q;

  logic [15:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 16'd1;
    else           run_cnt <= '0;
  end

  // R4
  done_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == 16'(2*Q)));

  // R4
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !load) |=> busy);

  // R9
  load_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && load) |=> !busy);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load) |=> $stable(rd_data));

  for (genvar d = 0; d < NS; d++) begin : g_diag
    // R7
    diag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(rd_data[(d*NS+d)*W +: W]));
  end
endmodule

bind hcube_transpose hcube_transpose_chk #(.Q(Q), .W(W)) chk_i (.*);

// File: tb/hcube_transpose_tb_top.sv
module hcube_transpose_tb_top;
  localparam int Q  = 2;
  localparam int W  = 8;
  localparam int NS = 1 << Q;
  localparam int N  = NS * NS;
  localparam int NW = N * W;
  localparam time CLK_PERIOD = 10ns;
  localparam int NV = 4;

  localparam logic [2*NW-1:0] VEC [NV] = '{
    {128'h1f1e1d1c_1b1a1918_17161514_13121110, 128'h1f1b1713_1e1a1612_1d191511_1c181410},
    {128'hffffffff_ffffffff_ffffffff_ffffffff, 128'hffffffff_ffffffff_ffffffff_ffffffff},
    {128'h00000000_00000000_00000000_00005a00, 128'h00000000_00000000_0000005a_00000000},
    {128'h00c30000_00000000_00000000_00000000, 128'h00000000_c3000000_00000000_00000000}
  };
  localparam logic [NW-1:0] MID0 = 128'h1f1e1716_1b1a1312_1d1c1514_19181110;

  logic clk = 1'b0, rst_n = 1'b0, load = 1'b0, start = 1'b0;
  logic [NW-1:0] load_data = '0;
  logic busy, done;
  logic [NW-1:0] rd_data;
  int total = 0, fails = 0, wd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hcube_transpose #(.Q(Q), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(load_data),
    .start(start), .busy(busy), .done(done), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [NW-1:0] act, input logic [NW-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic diag_eq(input logic [NW-1:0] x, input logic [NW-1:0] y);
    for (int d = 0; d < NS; d++)
      if (x[(d*NS+d)*W +: W] !== y[(d*NS+d)*W +: W]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic do_load(input logic [NW-1:0] v);
    load = 1'b1; load_data = v;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic do_run(input bit inj, output int cyc, output logic [NW-1:0] snap, output bit dok);
    logic [NW-1:0] base;
    base = rd_data; cyc = 0; snap = '0; dok = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 100) begin
      if (!diag_eq(rd_data, base)) dok = 1'b0;
      @(negedge clk);
      cyc++;
      start = inj && cyc == 1;
      load  = inj && cyc == 1;
      if (inj && cyc == 1) load_data = ~base;
      if (cyc == 2) snap = rd_data;
    end
    start = 1'b0; load = 1'b0;
  endtask

  initial begin
    int cyc;
    logic [NW-1:0] snap, hold;
    bit dok;
    repeat (2) @(negedge clk);
    // R8
    chk("R8 busy", NW'(busy), '0);
    chk("R8 done", NW'(done), '0);
    chk("R8 rd_data", rd_data, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int t = 0; t < NV; t++) begin
      do_load(VEC[t][2*NW-1:NW]);
      chk("R1 load", rd_data, VEC[t][2*NW-1:NW]);
      do_run(1'b0, cyc, snap, dok);
      chk("R2 transpose", rd_data, VEC[t][NW-1:0]);
      chk("R4 run length", NW'(cyc), NW'(2*Q));
      chk("R7 diagonal", NW'(dok), NW'(1));
      if (t == 0) chk("R3 first round", snap, MID0);
    end

    hold = rd_data;
    repeat (3) @(negedge clk);
    chk("R10 idle hold", rd_data, hold);
    @(negedge clk);
    chk("R4 done low", NW'(done), '0);

    do_load(VEC[0][2*NW-1:NW]);
    do_run(1'b1, cyc, snap, dok);
    chk("R5 start ignored", NW'(cyc), NW'(2*Q));
    chk("R6 load ignored", rd_data, VEC[0][NW-1:0]);
    @(negedge clk);
    chk("R5 no restart", NW'(busy), '0);

    do_load(VEC[3][2*NW-1:NW]);
    do_run(1'b0, cyc, snap, dok);
    do_run(1'b0, cyc, snap, dok);
    chk("R11 double run", rd_data, VEC[3][2*NW-1:NW]);

    load = 1'b1; start = 1'b1; load_data = VEC[2][2*NW-1:NW];
    @(negedge clk);
    load = 1'b0; start = 1'b0;
    chk("R9 start dropped", NW'(busy), '0);
    chk("R9 load taken", rd_data, VEC[2][2*NW-1:NW]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 start cycle hold", rd_data, VEC[2][2*NW-1:NW]);
    repeat (2*Q + 2) @(negedge clk);
    chk("R2 after direct start", rd_data, VEC[2][NW-1:0]);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      total++; fails++;
      $display("FAIL watchdog act=%0d exp=<20000", wd);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule